// File: doc/BRIEF.md
# SCSI Controller Status and Interrupt Register File

This block holds the byte-wide registers through which software watches a simple SCSI bus controller: status, interrupt cause, sequence step, FIFO fill count and configuration register 1. It also decodes the command register. Each command written there loads a fixed pattern into those registers and may raise the interrupt. No bus signalling takes place. Commands that would drive the SCSI bus produce only their register side effects.

The host reaches the registers through a byte-addressed port. The register index is the address shifted right by `STRIDE_SHIFT`, and the address bits below the stride are ignored. Read data is combinational from the current register contents, so a read returns the value held before its own side effects. Those side effects take effect at the clock edge that ends the read. The transfer engine reports the end of a transfer with a one-cycle `xfer_done` strobe. If `xfer_done` arrives in the same cycle as a host access, its register updates are applied after the host's.

Register indexes (after the shift): 0 status, 1 interrupt cause, 2 sequence step, 3 FIFO flags, 4 command (write), 5 configuration 1, 6 FIFO data (write), 7 spare. Reads of indexes 4, 6 and 7 return 0.

Top module: `scsic_stat_regs`

## Requirements
- R1: Reset value. After reset, every register reads 0 except configuration 1, which reads 8'h07, and `irq` is low.
- R2: Interrupt line.
  - `irq` is a level that equals status bit 7.
  - Events that raise it while it is already set change nothing.
  - Once set, it stays set until the interrupt-cause register is read or the block is reset.
- R3: Reading the interrupt-cause register.
  - A byte read of index 1 returns the old value.
  - It then zeroes that register, clears status bit 4 (terminal count) and status bit 7, and loads the sequence step with 4.
- R4: Flush, opcode 8'h01.
  - The interrupt cause becomes 8'h08 (function complete).
  - The sequence step and the FIFO count become 0.
  - `irq` is not raised.
- R5: Bus reset, opcode 8'h03.
  - The interrupt cause becomes 8'h80.
  - The interrupt is raised only when bit 6 of configuration 1 (report disable) is 0.
- R6: Initiator completion, opcode 8'h11.
  - The interrupt cause becomes 8'h08.
  - Status bits [2:0] are set to 3'b111 (message-in phase).
  - The interrupt is raised.
- R7: Message accepted, opcode 8'h12.
  - The interrupt cause becomes 8'h20 (disconnect).
  - The sequence step and the FIFO count become 0.
  - The interrupt is raised.
- R8: Selection commands and NOP.
  - Opcodes 8'h44 (enable selection) and 8'h45 (disable selection) write 0 to the interrupt cause and leave the status register and `irq` unchanged.
  - Opcode 8'h00 changes no register.
- R9: Any other opcode loads 8'h40 (illegal command) into the interrupt cause and raises the interrupt.
- R10: Transfer done. `xfer_done` sets status bits 4 and 7, loads the interrupt cause with 8'h10 (bus service), and zeroes the sequence step and the FIFO count.
- R11: Access widths.
  - Reads are byte-only. A 32-bit read (`bus_word`=1) returns 0 and has no side effect.
  - A write may be either width. Only bits [7:0] are used.
- R12: Opcode, addressing and FIFO.
  - Opcode bit 7 is ignored, so a command is decoded from bits [6:0].
  - Address bits below `STRIDE_SHIFT` are ignored.
  - A write to index 6 raises the FIFO count, saturating at `FIFO_DEPTH`. The count reads back through index 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous hard reset |
| bus_addr | input | IDX_W+STRIDE_SHIFT | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle; it wins over `bus_rd` |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_word | input | 1 | 1 for a 32-bit access, 0 for a byte access |
| bus_wdata | input | 32 | Write data; only [7:0] is used |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high |
| xfer_done | input | 1 | Completion strobe from the transfer engine |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situation to reach is an interrupt that is already pending when a second command arrives. The bench must then show that the second command neither duplicates the interrupt nor drops it. It must also show that selection commands wipe the cause without lowering the line, and that only the cause-register read clears it. The stimulus first issues an initiator-completion command to raise the line. It then follows with NOP, selection, illegal and word-width read accesses. Each time it probes `irq` and the status register before performing the single clearing read. A second case needs configuration 1 rewritten between two bus-reset commands so that the report-disable mask is seen both ways.

// File: rtl/scsic_pkg.sv
package scsic_pkg;

   localparam int IDX_W = 3;

   typedef enum logic [IDX_W-1:0] {
      RX_STAT  = 3'd0,
      RX_INTR  = 3'd1,
      RX_SEQ   = 3'd2,
      RX_FLAGS = 3'd3,
      RX_CMD   = 3'd4,
      RX_CFG1  = 3'd5,
      RX_FIFO  = 3'd6,
      RX_SPARE = 3'd7
   } reg_idx_e;

   // status bit positions
   localparam int ST_INT = 7;
   localparam int ST_TC  = 4;
   localparam logic [2:0] PH_MSGIN = 3'b111;

   // interrupt cause codes
   localparam logic [7:0] IC_RST   = 8'h80;
   localparam logic [7:0] IC_ILL   = 8'h40;
   localparam logic [7:0] IC_DISC  = 8'h20;
   localparam logic [7:0] IC_BSVC  = 8'h10;
   localparam logic [7:0] IC_FDONE = 8'h08;

   localparam logic [2:0] SEQ_DONE = 3'd4;

   localparam int         CFG1_NOREPORT = 6;
   localparam logic [7:0] CFG1_INIT     = 8'h07;

   localparam int OP_W = 7;
   localparam logic [OP_W-1:0] OP_NOP    = 7'h00;
   localparam logic [OP_W-1:0] OP_FLUSH  = 7'h01;
   localparam logic [OP_W-1:0] OP_BUSRST = 7'h03;
   localparam logic [OP_W-1:0] OP_ICCS   = 7'h11;
   localparam logic [OP_W-1:0] OP_MSGOK  = 7'h12;
   localparam logic [OP_W-1:0] OP_SELON  = 7'h44;
   localparam logic [OP_W-1:0] OP_SELOFF = 7'h45;

   typedef struct packed {
      logic       load_ic;
      logic [7:0] ic_val;
      logic       clr_seq;
      logic       flush;
      logic       set_msgin;
      logic       raise;
      logic       raise_maskable;
   } cmd_act_t;

endpackage

// File: rtl/scsic_idx_dec.sv
module scsic_idx_dec #(
   parameter  int SHIFT  = 2,
   localparam int ADDR_W = scsic_pkg::IDX_W + SHIFT
) (
   input  logic [ADDR_W-1:0]   addr,
   output scsic_pkg::reg_idx_e idx
);
   import scsic_pkg::*;

   generate
      if (SHIFT == 0) begin : g_flat
         assign idx = reg_idx_e'(addr);
      end else begin : g_stride
         logic [ADDR_W-1:0] shifted;
         assign shifted = addr >> SHIFT;
         assign idx     = reg_idx_e'(shifted[IDX_W-1:0]);
      end
   endgenerate

endmodule

// File: rtl/scsic_cmd_dec.sv
module scsic_cmd_dec (
   input  logic [scsic_pkg::OP_W-1:0] opcode,
   output scsic_pkg::cmd_act_t        act
);
   import scsic_pkg::*;

   always_comb begin
      act = '0;
      unique case (opcode)
         OP_NOP: ;
         OP_FLUSH: begin
            act.load_ic = 1'b1;
            act.ic_val  = IC_FDONE;
            act.clr_seq = 1'b1;
            act.flush   = 1'b1;
         end
         OP_BUSRST: begin
            act.load_ic        = 1'b1;
            act.ic_val         = IC_RST;
            act.raise_maskable = 1'b1;
         end
         OP_ICCS: begin
            act.load_ic   = 1'b1;
            act.ic_val    = IC_FDONE;
            act.set_msgin = 1'b1;
            act.raise     = 1'b1;
         end
         OP_MSGOK: begin
            act.load_ic = 1'b1;
            act.ic_val  = IC_DISC;
            act.clr_seq = 1'b1;
            act.flush   = 1'b1;
            act.raise   = 1'b1;
         end
         OP_SELON, OP_SELOFF: begin
            act.load_ic = 1'b1;
            act.ic_val  = 8'h00;
         end
         default: begin
            act.load_ic = 1'b1;
            act.ic_val  = IC_ILL;
            act.raise   = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/scsic_fifo_cnt.sv
module scsic_fifo_cnt #(
   parameter  int DEPTH = 16,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             flush,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

   always_ff @(posedge clk) begin
      if (!rst_n)               cnt <= '0;
      else if (flush)           cnt <= '0;
      else if (push && cnt != FULL) cnt <= cnt + 1'b1;
   end

   AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= FULL);                                                  // R12
   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> cnt == '0);                                          // R4
   AST_PUSH_SAT: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !flush && cnt == FULL) |=> cnt == FULL);              // R12

endmodule

// File: rtl/scsic_stat_regs.sv
module scsic_stat_regs #(
   parameter  int STRIDE_SHIFT = 2,
   parameter  int FIFO_DEPTH   = 16,
   localparam int ADDR_W       = scsic_pkg::IDX_W + STRIDE_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic              bus_word,
   input  logic [31:0]       bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              xfer_done,
   output logic              irq
);
   import scsic_pkg::*;

   localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

   generate
      if (STRIDE_SHIFT < 0 || STRIDE_SHIFT > 8) begin : g_bad_stride
         $error("STRIDE_SHIFT must lie in 0..8");
      end
      if (FIFO_DEPTH < 1 || FIFO_DEPTH > 255) begin : g_bad_depth
         $error("FIFO_DEPTH must lie in 1..255");
      end
   endgenerate

   reg_idx_e         idx;
   cmd_act_t         act;
   logic [7:0]       wbyte;
   logic [7:0]       stat_q, intr_q, cfg1_q;
   logic [2:0]       seq_q;
   logic [CNT_W-1:0] fcnt;
   logic             rd_ok, intr_rd, cmd_wr, cfg1_wr, fifo_wr, raise_now;

   scsic_idx_dec #(.SHIFT(STRIDE_SHIFT)) i_idx (
      .addr (bus_addr),
      .idx  (idx)
   );

   assign wbyte = 8'(bus_wdata);

   scsic_cmd_dec i_cmd (
      .opcode (wbyte[OP_W-1:0]),
      .act    (act)
   );

   assign rd_ok   = bus_rd && !bus_wr && !bus_word;
   assign intr_rd = rd_ok && idx == RX_INTR;
   assign cmd_wr  = bus_wr && idx == RX_CMD;
   assign cfg1_wr = bus_wr && idx == RX_CFG1;
   assign fifo_wr = bus_wr && idx == RX_FIFO;

   assign raise_now = act.raise || (act.raise_maskable && !cfg1_q[CFG1_NOREPORT]);

   scsic_fifo_cnt #(.DEPTH(FIFO_DEPTH)) i_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (fifo_wr),
      .flush ((cmd_wr && act.flush) || xfer_done),
      .cnt   (fcnt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_q <= '0;
         intr_q <= '0;
         seq_q  <= '0;
         cfg1_q <= CFG1_INIT;
      end else begin
         if (intr_rd) begin
            intr_q         <= '0;
            stat_q[ST_TC]  <= 1'b0;
            stat_q[ST_INT] <= 1'b0;
            seq_q          <= SEQ_DONE;
         end
         if (cfg1_wr) cfg1_q <= wbyte;
         if (cmd_wr) begin
            if (act.load_ic)   intr_q      <= act.ic_val;
            if (act.clr_seq)   seq_q       <= '0;
            if (act.set_msgin) stat_q[2:0] <= PH_MSGIN;
            if (raise_now)     stat_q[ST_INT] <= 1'b1;
         end
         if (xfer_done) begin
            stat_q[ST_TC]  <= 1'b1;
            stat_q[ST_INT] <= 1'b1;
            intr_q         <= IC_BSVC;
            seq_q          <= '0;
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (rd_ok) begin
         unique case (idx)
            RX_STAT:  bus_rdata = stat_q;
            RX_INTR:  bus_rdata = intr_q;
            RX_SEQ:   bus_rdata = {5'b0, seq_q};
            RX_FLAGS: bus_rdata = 8'(fcnt);
            RX_CFG1:  bus_rdata = cfg1_q;
            default:  bus_rdata = '0;
         endcase
      end
   end

   assign irq = stat_q[ST_INT];

   AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (intr_rd && !xfer_done && !bus_wr) |=> (!irq && intr_q == 8'h00 && seq_q == SEQ_DONE)); // R3
   AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !intr_rd) |=> irq);                                                            // R2
   AST_RST_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && wbyte[OP_W-1:0] == OP_BUSRST && cfg1_q[CFG1_NOREPORT] && !irq && !xfer_done)
      |=> !irq);                                                                             // R5
   AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && wbyte[OP_W-1:0] == OP_NOP && !xfer_done)
      |=> ($stable(intr_q) && $stable(stat_q) && $stable(seq_q)));                           // R8
   AST_DONE_TC: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |=> (stat_q[ST_TC] && irq && intr_q == IC_BSVC));                            // R10
   AST_WORD_RD_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_word && !bus_wr && !xfer_done) |=> ($stable(intr_q) && $stable(irq)));  // R11
   AST_WORD_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_word) |-> bus_rdata == 8'h00);                                          // R11

endmodule

// File: tb/test_scsic_stat_regs.sv
module test_scsic_stat_regs;
   localparam int SH = 2;
   localparam int AW = 3 + SH;
   localparam int I_STAT = 0, I_INTR = 1, I_SEQ = 2, I_FLAGS = 3,
                  I_CMD = 4, I_CFG1 = 5, I_FIFO = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_wr = 1'b0, bus_rd = 1'b0, bus_word = 1'b0, xfer_done = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic [7:0]    bus_rdata;
   logic          irq;
   logic          probe = 1'b0;

   int n_cmp = 0, n_bad = 0;
   bit finished = 1'b0;

   typedef struct {
      bit         is_irq;
      logic [7:0] exp;
      string      tag;
   } item_t;
   item_t sbq[$];

   always #2 clk = ~clk;   // 250 MHz

   scsic_stat_regs #(.STRIDE_SHIFT(SH), .FIFO_DEPTH(16)) i_scsic_stat_regs (
      .clk, .rst_n, .bus_addr, .bus_wr, .bus_rd, .bus_word,
      .bus_wdata, .bus_rdata, .xfer_done, .irq
   );

   // monitor: compares at the falling edge
   always @(negedge clk) begin
      if (bus_rd || probe) begin
         item_t it;
         logic [7:0] act;
         if (sbq.size() == 0) begin
            n_bad++;
            $display("FAIL scoreboard empty: actual=%h expected=queued item", bus_rdata);
         end else begin
            it  = sbq.pop_front();
            act = it.is_irq ? {7'b0, irq} : bus_rdata;
            n_cmp++;
            if (act !== it.exp) begin
               n_bad++;
               $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic step();
      @(posedge clk); #1;
      bus_wr = 1'b0; bus_rd = 1'b0; bus_word = 1'b0; probe = 1'b0; xfer_done = 1'b0;
   endtask

   task automatic wr(input int idx, input logic [31:0] d, input bit word = 1'b0);
      bus_addr = AW'(idx << SH); bus_wdata = d; bus_word = word; bus_wr = 1'b1;
      step();
   endtask

   task automatic rd(input int idx, input logic [7:0] exp, input string tag,
                     input bit word = 1'b0, input int low = 0);
      item_t it;
      it.is_irq = 1'b0; it.exp = exp; it.tag = tag;
      sbq.push_back(it);
      bus_addr = AW'((idx << SH) | low); bus_word = word; bus_rd = 1'b1;
      step();
   endtask

   task automatic chk_irq(input logic exp, input string tag);
      item_t it;
      it.is_irq = 1'b1; it.exp = {7'b0, exp}; it.tag = tag;
      sbq.push_back(it);
      probe = 1'b1;
      step();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog R1..: actual=hung expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      step();

      // R1 reset state (sequence read before cause read)
      rd(I_STAT, 8'h00, "R1 stat");
      rd(I_SEQ, 8'h00, "R1 seq");
      rd(I_FLAGS, 8'h00, "R1 flags");
      rd(I_CFG1, 8'h07, "R1 cfg1");
      rd(I_INTR, 8'h00, "R1 intr");
      chk_irq(1'b0, "R1 irq");

      // R12 fifo count and saturation
      for (int i = 0; i < 3; i++) wr(I_FIFO, 32'h5A);
      rd(I_FLAGS, 8'h03, "R12 flags count");
      for (int i = 0; i < 15; i++) wr(I_FIFO, 32'h5A);
      rd(I_FLAGS, 8'h10, "R12 flags saturate");

      // R4 flush
      wr(I_CMD, 32'h01);
      chk_irq(1'b0, "R4 flush no irq");
      rd(I_FLAGS, 8'h00, "R4 flags");
      rd(I_SEQ, 8'h00, "R4 seq");
      rd(I_INTR, 8'h08, "R4 intr");
      rd(I_SEQ, 8'h04, "R3 seq done");

      // R6 + R12 (bit7 ignored), R3 read clear
      wr(I_CMD, 32'h91);
      chk_irq(1'b1, "R6 irq");
      rd(I_STAT, 8'h87, "R6 stat");
      rd(I_INTR, 8'h08, "R3 old value");
      chk_irq(1'b0, "R3 irq drop");
      rd(I_STAT, 8'h07, "R3 stat cleared");
      rd(I_INTR, 8'h00, "R3 intr zeroed");

      // R8 NOP
      wr(I_CMD, 32'h11);
      wr(I_CMD, 32'h00);
      rd(I_STAT, 8'h87, "R8 nop stat");
      chk_irq(1'b1, "R8 nop irq");
      rd(I_SEQ, 8'h04, "R8 nop seq");
      rd(I_INTR, 8'h08, "R8 nop intr");

      // R8 selection commands; R2 line kept
      wr(I_CMD, 32'h11);
      wr(I_CMD, 32'h44);
      chk_irq(1'b1, "R2 irq held after selon");
      rd(I_INTR, 8'h00, "R8 selon intr");
      chk_irq(1'b0, "R2 irq after read");
      wr(I_CMD, 32'h11);
      wr(I_CMD, 32'h45);
      rd(I_STAT, 8'h87, "R8 seloff stat");
      rd(I_INTR, 8'h00, "R8 seloff intr");

      // R7 message accepted
      wr(I_FIFO, 32'h1); wr(I_FIFO, 32'h2);
      wr(I_CMD, 32'h12);
      chk_irq(1'b1, "R7 irq");
      rd(I_SEQ, 8'h00, "R7 seq");
      rd(I_FLAGS, 8'h00, "R7 flags");
      rd(I_INTR, 8'h20, "R7 intr");

      // R5 bus reset, report enabled then disabled
      wr(I_CMD, 32'h03);
      chk_irq(1'b1, "R5 irq reported");
      rd(I_INTR, 8'h80, "R5 intr");
      wr(I_CFG1, 32'h47);
      wr(I_CMD, 32'h03);
      chk_irq(1'b0, "R5 irq masked");
      rd(I_INTR, 8'h80, "R5 intr masked");
      rd(I_CFG1, 8'h47, "R5 cfg1");

      // R9 illegal
      wr(I_CMD, 32'h2A);
      chk_irq(1'b1, "R9 irq");
      rd(I_INTR, 8'h40, "R9 intr");
      wr(I_CMD, 32'h02);
      rd(I_INTR, 8'h40, "R9 intr code 02");

      // R2 raise while already set
      wr(I_CMD, 32'h11);
      wr(I_CMD, 32'h2A);
      rd(I_STAT, 8'h87, "R2 stat double raise");
      rd(I_INTR, 8'h40, "R2 intr");
      chk_irq(1'b0, "R2 single clear");

      // R10 transfer done
      wr(I_FIFO, 32'h7);
      xfer_done = 1'b1; step();
      chk_irq(1'b1, "R10 irq");
      rd(I_STAT, 8'h97, "R10 stat");
      rd(I_SEQ, 8'h00, "R10 seq");
      rd(I_FLAGS, 8'h00, "R10 flags");
      rd(I_INTR, 8'h10, "R10 intr");
      rd(I_STAT, 8'h07, "R10 stat after read");

      // R11 access widths
      wr(I_CMD, 32'h11);
      rd(I_INTR, 8'h00, "R11 word read", 1'b1);
      chk_irq(1'b1, "R11 word read inert");
      rd(I_INTR, 8'h08, "R11 byte read");
      wr(I_CFG1, 32'hABCD_1205, 1'b1);
      rd(I_CFG1, 8'h05, "R11 word write low byte");

      // R12 stride low bits ignored
      rd(I_CFG1, 8'h05, "R12 stride low bits", 1'b0, 3);
      bus_addr = AW'((I_FIFO << SH) | 2); bus_wdata = 32'h9; bus_wr = 1'b1; step();
      rd(I_FLAGS, 8'h01, "R12 stride write");

      step();
      if (sbq.size() != 0) begin
         n_bad++;
         $display("FAIL scoreboard leftover: actual=%0d expected=0", sbq.size());
      end
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule